// File: doc/BRIEF.md
# Cache error recovery sequencer

This block takes error reports from the protection checkers that guard a core's TLB, instruction cache and data cache RAMs, stalls the access that raised each error, and steps through the recovery that suits the RAM concerned. Each recovery is a short chain of commands sent to outside agents: an invalidate agent, an eviction agent that can write a line back, a refill agent, and a page-walk agent. Every command is a request/acknowledge handshake. When the last acknowledge of a chain arrives, the stall is released and a one-cycle report states where the error was, whether it was a double-bit error, whether dirty data may have been lost, whether the location keeps failing, and whether the stalled access must be replayed.

The recovery depends on the source. For a TLB entry, the entry is invalidated and a page walk reloads it. For the instruction cache, tag or data, both lines of the set are invalidated and the line is refilled. For the data cache, the line is evicted and then refilled. A tag error makes the eviction take its address from the duplicate tag copy. A data error has single-bit flips corrected during the write-back. A dirty-flag error is corrected in the eviction and needs no refill. Reports that arrive together are served in a fixed order, and the rest wait in a per-source slot. A tracker counts back-to-back recoveries at the same location, so that a permanent fault is flagged instead of looping forever.

Top module: `cache_err_seq`

## Requirements
- R1: After reset, `stall`, every command request and `rpt_vld` are low.
- R2: `stall` is high from the cycle after an error report is presented. It goes low in the cycle after the final acknowledge of the last queued recovery, which is the same cycle in which `rpt_vld` pulses. While further reports wait, it stays high.
- R3: When reports arrive together they are served in the order TLB, instruction cache, data cache. None is lost. `rpt_src` encodes TLB=0, instruction cache=1, data cache=2.
- R4: A TLB report issues an invalidate with `inv_tlb`=1 and `inv_idx` equal to the entry, then a page walk for the same entry, and reports `rpt_replay`=1.
- R5: An instruction cache report issues an invalidate of the whole set (`inv_tlb`=0, `inv_idx` = set), then a refill with `fetch_dcache`=0 and `fetch_way`=0, and reports `rpt_replay`=1.
- R6: A data cache report with `dc_err_ram`=0 (tag) issues an eviction with `evict_dup_tag`=1 and `evict_fix`=0, then a refill with `fetch_dcache`=1 for the same set and way.
- R7: With `dc_err_ram`=1 (data), the eviction has `evict_dup_tag`=0 and `evict_fix` = not `dc_err_dbl`, and a refill follows. The report gives `rpt_dbl` = `dc_err_dbl` and `rpt_corrupt` = `dc_err_dbl` AND `dc_err_dirty`. For every other kind of error both flags are 0.
- R8: With `dc_err_ram`=2 (dirty flag), only an eviction with `evict_fix`=1 is issued. There is no refill, and `rpt_replay`=0.
- R9: A data cache report with `dc_err_ram`=3 (hint bits) is ignored: there is no stall, no command and no report.
- R10: A request stays high with stable fields until its acknowledge is sampled. It drops in the next cycle, and the next step of the chain requests in that same cycle.
- R11: For each source, the location (index and way) of each served report is compared with the previous one served from that source. The count is 1 on a new location and increments, saturating, on a repeat. `rpt_hard` is 1 when `hard_limit` is nonzero and the count is at least `hard_limit`.
- R12: A report from a source whose slot is already waiting is dropped, and the waiting report is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_limit | input | CNT_W | Repeat count that flags a hard fault, 0 disables |
| tlb_err_vld | input | 1 | TLB entry parity error |
| tlb_err_idx | input | TLB_W | TLB entry index |
| ic_err_vld | input | 1 | Instruction cache tag or data parity error |
| ic_err_set | input | SET_W | Instruction cache set |
| dc_err_vld | input | 1 | Data cache error |
| dc_err_set | input | SET_W | Data cache set |
| dc_err_way | input | WAY_W | Data cache way |
| dc_err_ram | input | 2 | 0 tag, 1 data, 2 dirty flag, 3 hint bits |
| dc_err_dbl | input | 1 | Double-bit error in a data granule |
| dc_err_dirty | input | 1 | Line held dirty data |
| stall | output | 1 | Hold the faulting access |
| inv_req | output | 1 | Invalidate request |
| inv_tlb | output | 1 | 1 TLB entry, 0 instruction cache set (both lines) |
| inv_idx | output | IDX_W | Entry or set to invalidate |
| inv_ack | input | 1 | Invalidate done |
| evict_req | output | 1 | Clean-and-invalidate request |
| evict_set | output | SET_W | Set to evict |
| evict_way | output | WAY_W | Way to evict |
| evict_dup_tag | output | 1 | Take the address from the duplicate tag copy |
| evict_fix | output | 1 | Correct single-bit errors during write-back |
| evict_ack | input | 1 | Eviction done |
| fetch_req | output | 1 | Refill request |
| fetch_dcache | output | 1 | 1 data cache, 0 instruction cache |
| fetch_set | output | SET_W | Set to refill |
| fetch_way | output | WAY_W | Way to refill |
| fetch_ack | input | 1 | Refill done |
| walk_req | output | 1 | Page walk request |
| walk_idx | output | TLB_W | TLB entry to reload |
| walk_ack | input | 1 | Page walk done |
| rpt_vld | output | 1 | One-cycle completion report |
| rpt_src | output | 2 | Source of the error |
| rpt_idx | output | IDX_W | Entry or set |
| rpt_way | output | WAY_W | Way (0 for TLB and instruction cache) |
| rpt_dbl | output | 1 | Double-bit error seen |
| rpt_corrupt | output | 1 | Dirty data may be lost |
| rpt_hard | output | 1 | Location keeps failing |
| rpt_replay | output | 1 | 1 replay the access, 0 continue |

## Verification
The hardest state to reach is the one where all three sources are waiting at once while a chain is still running, and a second report then comes in for a source whose slot is already full. Only then do the service order and the dropping of the late report show up at the ports. The stimulus stretches every acknowledge over several cycles to keep the sequencer busy. It fires all three sources in a single cycle, and in a separate pass it sends two instruction cache reports one after another during a TLB recovery. The repeat-location count is driven by serving the same set several times with a small `hard_limit`, then moving to a new set.

// File: rtl/cer_pkg.sv
package cer_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_TLB = 2'd0,
    SRC_IC  = 2'd1,
    SRC_DC  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    RAM_TAG   = 2'd0,
    RAM_DATA  = 2'd1,
    RAM_DIRTY = 2'd2,
    RAM_HINT  = 2'd3
  } dram_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INV   = 3'd1,
    ST_EVICT = 3'd2,
    ST_FETCH = 3'd3,
    ST_WALK  = 3'd4
  } st_e;
endpackage

// File: rtl/cer_arb.sv
module cer_arb #(
  parameter int NSRC  = 3,
  parameter int REC_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       in_vld,
  input  logic [NSRC*REC_W-1:0] in_rec,
  input  logic                  take,
  output logic                  sel_vld,
  output logic [1:0]            sel_src,
  output logic [REC_W-1:0]      sel_rec,
  output logic                  pend_any_n
);
  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  grant;
  logic [NSRC-1:0]  keep;
  logic [NSRC-1:0]  pend_n;
  logic [REC_W-1:0] rec_q [NSRC];

  // fixed priority, lowest source number first
  always_comb begin
    grant   = '0;
    sel_vld = 1'b0;
    sel_src = '0;
    sel_rec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (take && pend_q[i] && !sel_vld) begin
        grant[i] = 1'b1;
        sel_vld  = 1'b1;
        sel_src  = 2'(i);
        sel_rec  = rec_q[i];
      end
    end
  end

  assign keep       = pend_q & ~grant;
  assign pend_n     = keep | in_vld;
  assign pend_any_n = |pend_n;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_n;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (in_vld[g] && !keep[g]) rec_q[g] <= in_rec[g*REC_W +: REC_W];
    end

    p_pend_kept_r3: assert property (@(posedge clk) disable iff (rst)
      (pend_q[g] && !grant[g]) |=> pend_q[g]);
  end
endmodule

// File: rtl/cer_hard.sv
module cer_hard #(
  parameter int NSRC  = 3,
  parameter int LOC_W = 9,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [1:0]       upd_src,
  input  logic [LOC_W-1:0] upd_loc,
  input  logic [CNT_W-1:0] limit,
  output logic             hard_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LOC_W-1:0] last_q [NSRC];
  logic [CNT_W-1:0] cnt_q  [NSRC];
  logic [NSRC-1:0]  lv_q;
  logic             same;
  logic [CNT_W-1:0] cnt_cur;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    same    = 1'b0;
    cnt_cur = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (upd_src == 2'(i)) begin
        same    = lv_q[i] && (last_q[i] == upd_loc);
        cnt_cur = cnt_q[i];
      end
    end
    if (!same)                 cnt_n = CNT_W'(1);
    else if (cnt_cur == CNT_MAX) cnt_n = CNT_MAX;
    else                       cnt_n = cnt_cur + CNT_W'(1);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_trk
    always_ff @(posedge clk) begin
      if (rst) begin
        lv_q[g]   <= 1'b0;
        cnt_q[g]  <= '0;
        last_q[g] <= '0;
      end else if (upd && upd_src == 2'(g)) begin
        lv_q[g]   <= 1'b1;
        cnt_q[g]  <= cnt_n;
        last_q[g] <= upd_loc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      hard_q <= 1'b0;
    else if (upd) hard_q <= (limit != '0) && (cnt_n >= limit);
  end

  p_hard_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (upd && limit == '0) |=> !hard_q);
endmodule

// File: rtl/cer_seq.sv
module cer_seq
  import cer_pkg::*;
#(
  parameter int TLB_W = 5,
  parameter int SET_W = 7,
  parameter int WAY_W = 2,
  parameter int IDX_W = 7,
  parameter int REC_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_vld,
  input  logic [1:0]       sel_src,
  input  logic [REC_W-1:0] sel_rec,
  input  logic             pend_any_n,
  input  logic             hard,
  output logic             take,
  output logic             stall,
  output logic             inv_req,
  output logic             inv_tlb,
  output logic [IDX_W-1:0] inv_idx,
  input  logic             inv_ack,
  output logic             evict_req,
  output logic [SET_W-1:0] evict_set,
  output logic [WAY_W-1:0] evict_way,
  output logic             evict_dup_tag,
  output logic             evict_fix,
  input  logic             evict_ack,
  output logic             fetch_req,
  output logic             fetch_dcache,
  output logic [SET_W-1:0] fetch_set,
  output logic [WAY_W-1:0] fetch_way,
  input  logic             fetch_ack,
  output logic             walk_req,
  output logic [TLB_W-1:0] walk_idx,
  input  logic             walk_ack,
  output logic             rpt_vld,
  output logic [1:0]       rpt_src,
  output logic [IDX_W-1:0] rpt_idx,
  output logic [WAY_W-1:0] rpt_way,
  output logic             rpt_dbl,
  output logic             rpt_corrupt,
  output logic             rpt_hard,
  output logic             rpt_replay
);
  localparam int WAY_LSB = IDX_W;
  localparam int RAM_LSB = IDX_W + WAY_W;
  localparam int DBL_BIT = RAM_LSB + 2;
  localparam int DRT_BIT = RAM_LSB + 3;

  st_e              state_q, state_n;
  src_e             src_q;
  dram_e            ram_q;
  logic [IDX_W-1:0] idx_q;
  logic [WAY_W-1:0] way_q;
  logic             dbl_q, dirty_q;
  logic             accept, finish;
  logic             dc_data_dbl;

  assign take = (state_q == ST_IDLE);

  always_comb begin
    state_n = state_q;
    accept  = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (sel_vld) begin
        accept  = 1'b1;
        state_n = (sel_src == SRC_DC) ? ST_EVICT : ST_INV;
      end
      ST_INV: if (inv_ack) state_n = (src_q == SRC_TLB) ? ST_WALK : ST_FETCH;
      ST_WALK: if (walk_ack) begin
        state_n = ST_IDLE;
        finish  = 1'b1;
      end
      ST_EVICT: if (evict_ack) begin
        if (ram_q == RAM_DIRTY) begin
          state_n = ST_IDLE;
          finish  = 1'b1;
        end else begin
          state_n = ST_FETCH;
        end
      end
      ST_FETCH: if (fetch_ack) begin
        state_n = ST_IDLE;
        finish  = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign dc_data_dbl = (src_q == SRC_DC) && (ram_q == RAM_DATA) && dbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      stall   <= 1'b0;
      rpt_vld <= 1'b0;
      src_q   <= SRC_TLB;
      ram_q   <= RAM_TAG;
      idx_q   <= '0;
      way_q   <= '0;
      dbl_q   <= 1'b0;
      dirty_q <= 1'b0;
      rpt_src <= '0;
      rpt_idx <= '0;
      rpt_way <= '0;
      rpt_dbl <= 1'b0;
      rpt_corrupt <= 1'b0;
      rpt_hard    <= 1'b0;
      rpt_replay  <= 1'b0;
    end else begin
      state_q <= state_n;
      stall   <= pend_any_n || (state_n != ST_IDLE);
      rpt_vld <= finish;
      if (accept) begin
        src_q   <= src_e'(sel_src);
        idx_q   <= sel_rec[IDX_W-1:0];
        way_q   <= sel_rec[WAY_LSB +: WAY_W];
        ram_q   <= dram_e'(sel_rec[RAM_LSB +: 2]);
        dbl_q   <= sel_rec[DBL_BIT];
        dirty_q <= sel_rec[DRT_BIT];
      end
      if (finish) begin
        rpt_src     <= src_q;
        rpt_idx     <= idx_q;
        rpt_way     <= way_q;
        rpt_dbl     <= dc_data_dbl;
        rpt_corrupt <= dc_data_dbl && dirty_q;
        rpt_hard    <= hard;
        rpt_replay  <= !((src_q == SRC_DC) && (ram_q == RAM_DIRTY));
      end
    end
  end

  assign inv_req       = (state_q == ST_INV);
  assign inv_tlb       = (src_q == SRC_TLB);
  assign inv_idx       = idx_q;
  assign evict_req     = (state_q == ST_EVICT);
  assign evict_set     = idx_q[SET_W-1:0];
  assign evict_way     = way_q;
  assign evict_dup_tag = (ram_q == RAM_TAG);
  assign evict_fix     = (ram_q == RAM_DIRTY) || ((ram_q == RAM_DATA) && !dbl_q);
  assign fetch_req     = (state_q == ST_FETCH);
  assign fetch_dcache  = (src_q == SRC_DC);
  assign fetch_set     = idx_q[SET_W-1:0];
  assign fetch_way     = way_q;
  assign walk_req      = (state_q == ST_WALK);
  assign walk_idx      = idx_q[TLB_W-1:0];

  p_inv_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (inv_req && !inv_ack) |=> (inv_req && $stable(inv_idx)));
  p_evict_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (evict_req && !evict_ack) |=> (evict_req && $stable(evict_set) && $stable(evict_way)));
  p_stall_cover_r2: assert property (@(posedge clk) disable iff (rst)
    (inv_req || evict_req || fetch_req || walk_req) |-> stall);
  p_stall_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> rpt_vld);
  p_walk_after_inv_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_req) |-> $past(inv_req && inv_ack));
endmodule

// File: rtl/cache_err_seq.sv
module cache_err_seq
  import cer_pkg::*;
#(
  parameter int TLB_W = 5,
  parameter int SET_W = 7,
  parameter int WAY_W = 2,
  parameter int CNT_W = 3,
  localparam int IDX_W = (TLB_W > SET_W) ? TLB_W : SET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] hard_limit,
  input  logic             tlb_err_vld,
  input  logic [TLB_W-1:0] tlb_err_idx,
  input  logic             ic_err_vld,
  input  logic [SET_W-1:0] ic_err_set,
  input  logic             dc_err_vld,
  input  logic [SET_W-1:0] dc_err_set,
  input  logic [WAY_W-1:0] dc_err_way,
  input  logic [1:0]       dc_err_ram,
  input  logic             dc_err_dbl,
  input  logic             dc_err_dirty,
  output logic             stall,
  output logic             inv_req,
  output logic             inv_tlb,
  output logic [IDX_W-1:0] inv_idx,
  input  logic             inv_ack,
  output logic             evict_req,
  output logic [SET_W-1:0] evict_set,
  output logic [WAY_W-1:0] evict_way,
  output logic             evict_dup_tag,
  output logic             evict_fix,
  input  logic             evict_ack,
  output logic             fetch_req,
  output logic             fetch_dcache,
  output logic [SET_W-1:0] fetch_set,
  output logic [WAY_W-1:0] fetch_way,
  input  logic             fetch_ack,
  output logic             walk_req,
  output logic [TLB_W-1:0] walk_idx,
  input  logic             walk_ack,
  output logic             rpt_vld,
  output logic [1:0]       rpt_src,
  output logic [IDX_W-1:0] rpt_idx,
  output logic [WAY_W-1:0] rpt_way,
  output logic             rpt_dbl,
  output logic             rpt_corrupt,
  output logic             rpt_hard,
  output logic             rpt_replay
);
  localparam int LOC_W = IDX_W + WAY_W;
  localparam int REC_W = LOC_W + 4;

  logic [REC_W-1:0]      tlb_rec, ic_rec, dc_rec;
  logic [NSRC-1:0]       in_vld;
  logic                  take, sel_vld, pend_any_n, hard;
  logic [1:0]            sel_src;
  logic [REC_W-1:0]      sel_rec;

  // record layout: {dirty, dbl, ram[1:0], way, idx}
  assign tlb_rec = {1'b0, 1'b0, 2'b00, {WAY_W{1'b0}}, IDX_W'(tlb_err_idx)};
  assign ic_rec  = {1'b0, 1'b0, 2'b00, {WAY_W{1'b0}}, IDX_W'(ic_err_set)};
  assign dc_rec  = {dc_err_dirty, dc_err_dbl, dc_err_ram, dc_err_way, IDX_W'(dc_err_set)};
  assign in_vld  = {dc_err_vld && (dc_err_ram != RAM_HINT), ic_err_vld, tlb_err_vld};

  cer_arb #(.NSRC(NSRC), .REC_W(REC_W)) u_arb (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rec({dc_rec, ic_rec, tlb_rec}),
    .take(take), .sel_vld(sel_vld), .sel_src(sel_src), .sel_rec(sel_rec),
    .pend_any_n(pend_any_n)
  );

  cer_hard #(.NSRC(NSRC), .LOC_W(LOC_W), .CNT_W(CNT_W)) u_hard (
    .clk(clk), .rst(rst), .upd(sel_vld), .upd_src(sel_src),
    .upd_loc(sel_rec[LOC_W-1:0]), .limit(hard_limit), .hard_q(hard)
  );

  cer_seq #(.TLB_W(TLB_W), .SET_W(SET_W), .WAY_W(WAY_W), .IDX_W(IDX_W), .REC_W(REC_W)) u_seq (
    .clk(clk), .rst(rst), .sel_vld(sel_vld), .sel_src(sel_src), .sel_rec(sel_rec),
    .pend_any_n(pend_any_n), .hard(hard), .take(take), .stall(stall),
    .inv_req(inv_req), .inv_tlb(inv_tlb), .inv_idx(inv_idx), .inv_ack(inv_ack),
    .evict_req(evict_req), .evict_set(evict_set), .evict_way(evict_way),
    .evict_dup_tag(evict_dup_tag), .evict_fix(evict_fix), .evict_ack(evict_ack),
    .fetch_req(fetch_req), .fetch_dcache(fetch_dcache), .fetch_set(fetch_set),
    .fetch_way(fetch_way), .fetch_ack(fetch_ack),
    .walk_req(walk_req), .walk_idx(walk_idx), .walk_ack(walk_ack),
    .rpt_vld(rpt_vld), .rpt_src(rpt_src), .rpt_idx(rpt_idx), .rpt_way(rpt_way),
    .rpt_dbl(rpt_dbl), .rpt_corrupt(rpt_corrupt), .rpt_hard(rpt_hard),
    .rpt_replay(rpt_replay)
  );
endmodule

// File: tb/sim_cache_err_seq.sv
module sim_cache_err_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TLB_W = 5, SET_W = 7, WAY_W = 2, CNT_W = 3, IDX_W = 7;
  localparam int WD_CYCLES = 100000;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic [CNT_W-1:0] hard_limit = '0;
  logic tlb_err_vld = 0, ic_err_vld = 0, dc_err_vld = 0;
  logic [TLB_W-1:0] tlb_err_idx = '0;
  logic [SET_W-1:0] ic_err_set = '0, dc_err_set = '0;
  logic [WAY_W-1:0] dc_err_way = '0;
  logic [1:0] dc_err_ram = '0;
  logic dc_err_dbl = 0, dc_err_dirty = 0;
  logic stall, inv_req, inv_tlb, evict_req, evict_dup_tag, evict_fix;
  logic fetch_req, fetch_dcache, walk_req;
  logic inv_ack = 0, evict_ack = 0, fetch_ack = 0, walk_ack = 0;
  logic [IDX_W-1:0] inv_idx, rpt_idx;
  logic [SET_W-1:0] evict_set, fetch_set;
  logic [WAY_W-1:0] evict_way, fetch_way, rpt_way;
  logic [TLB_W-1:0] walk_idx;
  logic rpt_vld, rpt_dbl, rpt_corrupt, rpt_hard, rpt_replay;
  logic [1:0] rpt_src;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int dly [4] = '{1, 1, 1, 1};
  exp_t q[$];
  int last_loc [3];
  bit last_v [3] = '{0, 0, 0};
  int cnt [3] = '{0, 0, 0};

  cache_err_seq #(.TLB_W(TLB_W), .SET_W(SET_W), .WAY_W(WAY_W), .CNT_W(CNT_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] it(input int t, input logic [27:0] f);
    return {4'(t), f};
  endfunction

  task automatic push(input logic [31:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic bit model_hard(input int s, input int loc);
    bit same = last_v[s] && (last_loc[s] == loc);
    cnt[s] = same ? ((cnt[s] == 7) ? 7 : cnt[s] + 1) : 1;
    last_v[s] = 1; last_loc[s] = loc;
    return (hard_limit != 0) && (cnt[s] >= int'(hard_limit));
  endfunction

  task automatic exp_tlb(input logic [TLB_W-1:0] idx);
    bit h = model_hard(0, int'(idx));
    push(it(1, 28'({1'b1, IDX_W'(idx)})), "R4 inv");
    push(it(4, 28'(idx)), "R4 walk");
    push(it(5, 28'({2'd0, IDX_W'(idx), 2'd0, 1'b0, 1'b0, h, 1'b1})), "R4/R11 report");
  endtask

  task automatic exp_ic(input logic [SET_W-1:0] s);
    bit h = model_hard(1, int'(s));
    push(it(1, 28'({1'b0, IDX_W'(s)})), "R5 inv");
    push(it(3, 28'({1'b0, 2'd0, s})), "R5 fetch");
    push(it(5, 28'({2'd1, IDX_W'(s), 2'd0, 1'b0, 1'b0, h, 1'b1})), "R5/R11 report");
  endtask

  task automatic exp_dc(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w,
                        input logic [1:0] ram, input logic dbl, input logic dirty);
    bit h = model_hard(2, int'(w) * 128 + int'(s));
    logic dd = (ram == 2'd1) && dbl;
    logic fix = (ram == 2'd2) || ((ram == 2'd1) && !dbl);
    push(it(2, 28'({ram == 2'd0, fix, w, s})), "R6/R7/R8 evict");
    if (ram != 2'd2) push(it(3, 28'({1'b1, w, s})), "R6/R7 fetch");
    push(it(5, 28'({2'd2, IDX_W'(s), w, dd, dd && dirty, h, ram != 2'd2})), "R7/R8 report");
  endtask

  task automatic send(input bit tv, input logic [TLB_W-1:0] ti, input bit iv, input logic [SET_W-1:0] is,
                      input bit dv, input logic [SET_W-1:0] ds, input logic [WAY_W-1:0] dw,
                      input logic [1:0] dr, input logic db, input logic dd);
    @(negedge clk);
    tlb_err_vld = tv; tlb_err_idx = ti;
    ic_err_vld = iv;  ic_err_set = is;
    dc_err_vld = dv;  dc_err_set = ds; dc_err_way = dw; dc_err_ram = dr;
    dc_err_dbl = db;  dc_err_dirty = dd;
    @(negedge clk);
    tlb_err_vld = 0; ic_err_vld = 0; dc_err_vld = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || stall);
    repeat (3) @(negedge clk);
  endtask

  task automatic sb_take(input logic [31:0] obs);
    exp_t e;
    if (q.size() == 0) begin
      chk(0, "R3/R9 unexpected item", obs, 32'h0);
    end else begin
      e = q.pop_front();
      chk(obs == e.v, e.tag, obs, e.v);
    end
  endtask

  function automatic logic req_of(input int ch);
    case (ch)
      0: return inv_req;
      1: return evict_req;
      2: return fetch_req;
      default: return walk_req;
    endcase
  endfunction

  function automatic logic [31:0] obs_of(input int ch);
    case (ch)
      0: return it(1, 28'({inv_tlb, inv_idx}));
      1: return it(2, 28'({evict_dup_tag, evict_fix, evict_way, evict_set}));
      2: return it(3, 28'({fetch_dcache, fetch_way, fetch_set}));
      default: return it(4, 28'(walk_idx));
    endcase
  endfunction

  task automatic set_ack(input int ch, input logic v);
    case (ch)
      0: inv_ack = v;
      1: evict_ack = v;
      2: fetch_ack = v;
      default: walk_ack = v;
    endcase
  endtask

  task automatic agent(input int ch);
    logic [31:0] o;
    bit hold;
    forever begin
      @(negedge clk);
      if (req_of(ch) === 1'b1) begin
        o = obs_of(ch);
        sb_take(o);
        hold = 1;
        for (int k = 0; k < dly[ch]; k++) begin
          @(negedge clk);
          if (req_of(ch) !== 1'b1 || obs_of(ch) != o) hold = 0;
        end
        chk(hold, "R10 request held until ack", {31'd0, hold}, 32'd1);
        set_ack(ch, 1'b1);
        @(negedge clk);
        set_ack(ch, 1'b0);
        chk(req_of(ch) == 1'b0, "R10 request drops after ack", {31'd0, req_of(ch)}, 32'd0);
      end
    end
  endtask

  // report monitor: compares the report, then checks the stall level against what remains queued
  initial begin
    forever begin
      @(negedge clk);
      if (rpt_vld === 1'b1) begin
        sb_take(it(5, 28'({rpt_src, rpt_idx, rpt_way, rpt_dbl, rpt_corrupt, rpt_hard, rpt_replay})));
        chk(stall == (q.size() != 0), "R2 stall level at report", {31'd0, stall}, {31'd0, q.size() != 0});
      end
    end
  end

  initial begin
    fork
      agent(0);
      agent(1);
      agent(2);
      agent(3);
    join_none
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_CYCLES && !finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WD_CYCLES);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(stall == 0, "R1 stall after reset", {31'd0, stall}, 0);
    chk({inv_req, evict_req, fetch_req, walk_req} == 4'b0, "R1 requests after reset",
        {28'd0, inv_req, evict_req, fetch_req, walk_req}, 0);
    chk(rpt_vld == 0, "R1 report after reset", {31'd0, rpt_vld}, 0);

    // R2 + R4: single TLB error
    exp_tlb(5'd19);
    @(negedge clk);
    tlb_err_vld = 1; tlb_err_idx = 5'd19;
    @(negedge clk);
    tlb_err_vld = 0;
    chk(stall == 1, "R2 stall rises the cycle after the report", {31'd0, stall}, 1);
    wait_idle();

    // R5
    dly = '{0, 2, 3, 1};
    exp_ic(7'd100);
    send(0, 0, 1, 7'd100, 0, 0, 0, 0, 0, 0);
    wait_idle();

    // R6, R7, R8
    dly = '{2, 3, 0, 2};
    exp_dc(7'd33, 2'd2, 2'd0, 0, 1);
    send(0, 0, 0, 0, 1, 7'd33, 2'd2, 2'd0, 0, 1);
    wait_idle();
    exp_dc(7'd40, 2'd1, 2'd1, 0, 1);
    send(0, 0, 0, 0, 1, 7'd40, 2'd1, 2'd1, 0, 1);
    wait_idle();
    exp_dc(7'd41, 2'd3, 2'd1, 1, 1);
    send(0, 0, 0, 0, 1, 7'd41, 2'd3, 2'd1, 1, 1);
    wait_idle();
    exp_dc(7'd42, 2'd0, 2'd1, 1, 0);
    send(0, 0, 0, 0, 1, 7'd42, 2'd0, 2'd1, 1, 0);
    wait_idle();
    exp_dc(7'd77, 2'd1, 2'd2, 0, 1);
    send(0, 0, 0, 0, 1, 7'd77, 2'd1, 2'd2, 0, 1);
    wait_idle();

    // R9: hint-bit report is ignored
    send(0, 0, 0, 0, 1, 7'd12, 2'd1, 2'd3, 0, 1);
    begin
      bit quiet = 1;
      for (int k = 0; k < 6; k++) begin
        if (stall || inv_req || evict_req || fetch_req || walk_req || rpt_vld) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R9 hint error leaves block idle", {31'd0, quiet}, 1);
    end

    // R3: all three in one cycle, slow acks
    dly = '{3, 2, 2, 3};
    exp_tlb(5'd7);
    exp_ic(7'd8);
    exp_dc(7'd9, 2'd1, 2'd1, 0, 0);
    send(1, 5'd7, 1, 7'd8, 1, 7'd9, 2'd1, 2'd1, 0, 0);
    wait_idle();

    // R12: second IC report while the first IC report waits is dropped
    exp_tlb(5'd2);
    exp_ic(7'd3);
    send(1, 5'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    send(0, 0, 1, 7'd3, 0, 0, 0, 0, 0, 0);
    send(0, 0, 1, 7'd9, 0, 0, 0, 0, 0, 0);
    wait_idle();
    chk(q.size() == 0, "R12 dropped report produced nothing", q.size(), 0);

    // R11: repeat count with a limit of 2
    hard_limit = 3'd2;
    dly = '{1, 1, 1, 1};
    for (int k = 0; k < 3; k++) begin
      exp_ic(7'd5);
      send(0, 0, 1, 7'd5, 0, 0, 0, 0, 0, 0);
      wait_idle();
    end
    exp_ic(7'd6);
    send(0, 0, 1, 7'd6, 0, 0, 0, 0, 0, 0);
    wait_idle();
    exp_tlb(5'd2);
    send(1, 5'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    wait_idle();

    chk(q.size() == 0, "R3 all expected items seen", q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule